// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block produces the system reset for a host processor from three causes: the arrival of power, a low main supply, and a watchdog that the host fails to service. It runs from a free-running timebase clock. A power-on strobe (`por_n`, low while power is absent) starts a fixed stabilisation hold. A comparator flag from the main rail holds reset for as long as the rail is low and restarts the full hold once the rail recovers. A watchdog counter runs while the host is out of reset. If the counter reaches the selected interval without a kick, reset is raised for one hold period and then released on its own.

The watchdog interval comes from a two-bit select register that is written by a strobe. The register has no reset term, so a power cycle leaves its value unchanged. It holds a power-up value of 00 and changes only when written. A second supply rail has its own comparator flag. That flag passes through a two-flop synchroniser to a separate fail output, with no hold delay, and the main reset logic plays no part in it.

The controller is a three-state machine. HOLD counts the stabilisation period and keeps reset high. LOWV keeps reset high while the main rail is low. RUN releases reset and lets the watchdog count. Transitions: power-on goes to HOLD. HOLD→LOWV when the rail is low. HOLD→RUN when the hold count completes. LOWV→HOLD when the rail recovers. RUN→LOWV when the rail is low. RUN→HOLD when the watchdog expires.

Top module: `supv_reset_ctrl`

## Requirements
- R1: After `por_n` rises, `rst_out` stays high for exactly HOLD_CYC clock edges (the state HOLD) and falls at the HOLD_CYC-th edge.
- R2: A high `vmain_low` raises `rst_out` at the third clock edge after it is applied, because of the two-flop synchroniser. `rst_out` stays high while the flag is set. After the flag clears, `rst_out` falls HOLD_CYC+3 edges later.
- R3: With the host out of reset and no kick, `rst_out` rises at the L-th edge after release, where L is the selected interval.
- R4: A watchdog reset lasts HOLD_CYC edges and then releases on its own.
- R5: A one-cycle `wdt_kick` pulse in RUN clears the watchdog count, so a full interval is counted again from the edge after the kick.
- R6: Select encoding: 00 gives WD_SHORT edges, 01 gives WD_MID, 10 gives WD_LONG. A new value takes effect from the edge at which it is written.
- R7: Select value 11 disables the watchdog, so `rst_out` stays low for any time without kicks.
- R8: The select register holds 00 at power-up. Pulsing `por_n` does not change it. Only `tsel_we` with `tsel_wdata` changes it.
- R9: The watchdog does not count while `rst_out` is high. After every release, the full interval runs again.
- R10: `rst_out` is high whenever `por_n` is low.
- R11: `v2_fail` equals `v2_low` delayed by two clock edges, whatever the state of `rst_out` or `vmain_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| por_n | input | 1 | Power-on strobe, low while power is absent; asynchronous clear |
| vmain_low | input | 1 | Main-rail low comparator flag, asynchronous |
| v2_low | input | 1 | Second-rail low comparator flag, asynchronous |
| wdt_kick | input | 1 | Host watchdog restart pulse, one clock wide, synchronous |
| tsel_we | input | 1 | Write strobe for the timeout select register |
| tsel_wdata | input | 2 | New timeout select value (00/01/10 interval, 11 off) |
| rst_out | output | 1 | System reset, active high |
| v2_fail | output | 1 | Second-rail fail flag, active high |

## Verification
The assertions assume three things about the inputs. `wdt_kick` and `tsel_we` are synchronous to `clk`. `por_n` is asserted long enough to clear the synchronisers and the state register. The comparator flags are level signals whose exact arrival cycle does not matter beyond the synchroniser.

The bench keeps within these limits. It changes every input only on the falling clock edge. Kicks and writes are single-cycle pulses. Every power-on pulse spans several clock edges. The comparator flags are held for many cycles at a time, so each reset cause is seen cleanly by the synchroniser before the next one is applied.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'b00,
        ST_LOWV = 2'b01,
        ST_RUN  = 2'b10
    } supv_state_e;

    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'b00,
        WD_SEL_MID   = 2'b01,
        WD_SEL_LONG  = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;

endpackage

// File: rtl/supv_sync2.sv
module supv_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
    parameter int HOLD_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);
endmodule

// File: rtl/supv_wdt.sv
module supv_wdt
    import supv_pkg::*;
#(
    parameter int WD_SHORT = 1024,
    parameter int WD_MID   = 8192,
    parameter int WD_LONG  = 65536,
    parameter int CW       = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          kick,
    input  logic          sel_we,
    input  logic [1:0]    sel_wdata,
    output logic [1:0]    sel_q,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    localparam logic [CW-1:0] LAST_S = CW'(WD_SHORT - 1);
    localparam logic [CW-1:0] LAST_M = CW'(WD_MID - 1);
    localparam logic [CW-1:0] LAST_L = CW'(WD_LONG - 1);

    // Persistent selection: no reset term, power-up value 00.
    logic [1:0] sel_r = 2'b00;
    always_ff @(posedge clk) begin
        if (sel_we) begin
            sel_r <= sel_wdata;
        end
    end
    assign sel_q = sel_r;

    logic [CW-1:0] last;
    logic          off;

    always_comb begin
        off  = 1'b0;
        last = LAST_L;
        unique case (wd_sel_e'(sel_r))
            WD_SEL_SHORT: last = LAST_S;
            WD_SEL_MID:   last = LAST_M;
            WD_SEL_LONG:  last = LAST_L;
            WD_SEL_OFF:   off  = 1'b1;
        endcase
    end

    assign expire = run && !kick && !off && (cnt >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || kick || off || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter int HOLD_CYC = 4096,
    parameter int WD_SHORT = 1024,
    parameter int WD_MID   = 8192,
    parameter int WD_LONG  = 65536
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       vmain_low,
    input  logic       v2_low,
    input  logic       wdt_kick,
    input  logic       tsel_we,
    input  logic [1:0] tsel_wdata,
    output logic       rst_out,
    output logic       v2_fail
);
    localparam int WMAX_A = (WD_SHORT > WD_MID) ? WD_SHORT : WD_MID;
    localparam int WMAX   = (WMAX_A > WD_LONG) ? WMAX_A : WD_LONG;
    localparam int CW     = $clog2(WMAX + 1);

    supv_state_e   state_q, state_d;
    logic          vlow_s;
    logic          hold_done;
    logic          wd_expire;
    logic          wd_run;
    logic [1:0]    sel_q;
    logic [CW-1:0] wd_cnt;

    supv_sync2 u_sync_main (
        .clk   (clk),
        .rst_n (por_n),
        .d     (vmain_low),
        .q     (vlow_s)
    );

    supv_sync2 u_sync_v2 (
        .clk   (clk),
        .rst_n (por_n),
        .d     (v2_low),
        .q     (v2_fail)
    );

    supv_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (por_n),
        .clear (state_q != ST_HOLD),
        .done  (hold_done)
    );

    assign wd_run = (state_q == ST_RUN) && !vlow_s;

    supv_wdt #(
        .WD_SHORT (WD_SHORT),
        .WD_MID   (WD_MID),
        .WD_LONG  (WD_LONG),
        .CW       (CW)
    ) u_wdt (
        .clk       (clk),
        .rst_n     (por_n),
        .run       (wd_run),
        .kick      (wdt_kick),
        .sel_we    (tsel_we),
        .sel_wdata (tsel_wdata),
        .sel_q     (sel_q),
        .cnt       (wd_cnt),
        .expire    (wd_expire)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (vlow_s)         state_d = ST_LOWV;
                else if (hold_done) state_d = ST_RUN;
            end
            ST_LOWV: begin
                if (!vlow_s)        state_d = ST_HOLD;
            end
            ST_RUN: begin
                if (vlow_s)         state_d = ST_LOWV;
                else if (wd_expire) state_d = ST_HOLD;
            end
            default:                state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        rst_out = (state_q != ST_RUN);
    end
endmodule

// File: rtl/supv_reset_checker.sv
module supv_reset_checker #(
    parameter int CW = 17
) (
    input logic          clk,
    input logic          por_n,
    input logic          rst_out,
    input logic          vlow_s,
    input logic          hold_done,
    input logic [CW-1:0] wd_cnt,
    input logic          wd_expire,
    input logic [1:0]    sel_q,
    input logic          tsel_we
);
    // R10: power absent means reset asserted
    always @(posedge clk) begin
        if (!por_n) begin
            a_r10_reset_while_off: assert (rst_out)
                else $error("a_r10_reset_while_off");
        end
    end

    // R2: a synchronised low-rail flag forces reset from the next edge
    a_r2_low_forces_reset: assert property (@(posedge clk) disable iff (!por_n)
        vlow_s |=> rst_out);

    // R1, R4: release only when the hold timer has completed
    a_r1_release_after_hold: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_out) |-> $past(hold_done));

    // R9: watchdog count is idle while reset is high
    a_r9_wd_idle_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        rst_out |-> (wd_cnt == '0));

    // R7: selection 11 never expires
    a_r7_off_never_expires: assert property (@(posedge clk) disable iff (!por_n)
        (sel_q == 2'b11) |-> !wd_expire);

    // R8: selection changes only after a write strobe
    a_r8_sel_only_by_write: assert property (@(posedge clk) disable iff (!por_n)
        !$past(tsel_we) |-> $stable(sel_q));
endmodule

bind supv_reset_ctrl supv_reset_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_out   (rst_out),
    .vlow_s    (vlow_s),
    .hold_done (hold_done),
    .wd_cnt    (wd_cnt),
    .wd_expire (wd_expire),
    .sel_q     (sel_q),
    .tsel_we   (tsel_we)
);

// File: tb/supv_reset_ctrl_test.sv
module supv_reset_ctrl_test;
    localparam int HOLD = 20;
    localparam int W0   = 40;
    localparam int W1   = 70;
    localparam int W2   = 100;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       vmain_low = 1'b0;
    logic       v2_low = 1'b0;
    logic       wdt_kick = 1'b0;
    logic       tsel_we = 1'b0;
    logic [1:0] tsel_wdata = 2'b00;
    logic       rst_out;
    logic       v2_fail;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit started = 1'b0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    supv_reset_ctrl #(
        .HOLD_CYC (HOLD), .WD_SHORT (W0), .WD_MID (W1), .WD_LONG (W2)
    ) uut (
        .clk(clk), .por_n(por_n), .vmain_low(vmain_low), .v2_low(v2_low),
        .wdt_kick(wdt_kick), .tsel_we(tsel_we), .tsel_wdata(tsel_wdata),
        .rst_out(rst_out), .v2_fail(v2_fail)
    );

    // behavioural reference: mode 0 holding, 1 low rail, 2 running
    int mode = 0, hold_n = 0, wd_n = 0, msel = 0;
    int mq[$] = '{0, 0};
    int vq[$] = '{0, 0};

    function automatic int lim_of(int s);
        if (s == 0) return W0;
        if (s == 1) return W1;
        return W2;
    endfunction

    always @(posedge clk) begin
        int nsel, low_s;
        nsel = tsel_we ? int'(tsel_wdata) : msel;
        if (!por_n) begin
            mode = 0; hold_n = 0; wd_n = 0;
            mq = '{0, 0}; vq = '{0, 0};
        end else begin
            low_s = mq[0];
            if (mode == 0) begin
                if (low_s != 0) mode = 1;
                else if (hold_n == HOLD - 1) begin mode = 2; wd_n = 0; end
                else hold_n++;
            end else if (mode == 1) begin
                if (low_s == 0) begin mode = 0; hold_n = 0; end
            end else begin
                if (low_s != 0) begin mode = 1; wd_n = 0; end
                else if (wdt_kick || msel == 3) wd_n = 0;
                else if (wd_n >= lim_of(msel) - 1) begin mode = 0; hold_n = 0; wd_n = 0; end
                else wd_n++;
            end
            if (mode != 0) hold_n = 0;
            void'(mq.pop_front()); mq.push_back(int'(vmain_low));
            void'(vq.pop_front()); vq.push_back(int'(v2_low));
        end
        msel = nsel;
        started = 1'b1;
    end

    always @(negedge clk) begin
        if (started && !done_flag) begin
            checks++;
            if (int'(rst_out) != (mode != 2 ? 1 : 0)) begin
                errors++;
                $display("FAIL %s model rst_out actual %0d expected %0d t=%0t",
                         cur_req, rst_out, (mode != 2), $time);
            end
            checks++;
            if (int'(v2_fail) != vq[0]) begin
                errors++;
                $display("FAIL R11 model v2_fail actual %0d expected %0d t=%0t",
                         v2_fail, vq[0], $time);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // negedges until rst_out equals lvl
    task automatic edges_until(logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst_out != lvl && n < 1000);
    endtask

    task automatic power_cycle();
        @(negedge clk); por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic write_sel(logic [1:0] v);
        @(negedge clk); tsel_wdata = v; tsel_we = 1'b1;
        @(negedge clk); tsel_we = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); wdt_kick = 1'b1;
        @(negedge clk); wdt_kick = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        cur_req = "R10";
        chk("R10", int'(rst_out), 1);
        chk("R11", int'(v2_fail), 0);

        // R1 power-up hold, R8 default 00 selection
        cur_req = "R1";
        por_n = 1'b1;
        edges_until(1'b0, n);
        chk("R1", n, HOLD);
        cur_req = "R3";
        edges_until(1'b1, n);
        chk("R3", n, W0);
        chk("R8", n, W0);
        cur_req = "R4";
        edges_until(1'b0, n);
        chk("R4", n, HOLD);

        // R5 kicks keep reset low for several intervals
        cur_req = "R5";
        for (int i = 0; i < 6; i++) begin
            repeat (W0 - 10) @(negedge clk);
            kick();
        end
        chk("R5", int'(rst_out), 0);
        edges_until(1'b1, n);
        chk("R5", n, W0);
        edges_until(1'b0, n);

        // R6 middle and long intervals
        cur_req = "R6";
        write_sel(2'b01);
        edges_until(1'b1, n);
        edges_until(1'b0, n);
        edges_until(1'b1, n);
        chk("R6", n, W1);
        edges_until(1'b0, n);
        write_sel(2'b10);
        edges_until(1'b1, n);
        edges_until(1'b0, n);
        edges_until(1'b1, n);
        chk("R6", n, W2);
        edges_until(1'b0, n);

        // R8 persistence across power cycle
        cur_req = "R8";
        write_sel(2'b01);
        power_cycle();
        edges_until(1'b0, n);
        chk("R1", n, HOLD);
        edges_until(1'b1, n);
        chk("R8", n, W1);
        edges_until(1'b0, n);

        // R2 main rail low, R11 second rail independent
        cur_req = "R2";
        repeat (5) @(negedge clk);
        vmain_low = 1'b1; v2_low = 1'b1;
        edges_until(1'b1, n);
        chk("R2", n, 3);
        chk("R11", int'(v2_fail), 1);
        repeat (W2 * 2) @(negedge clk);
        chk("R2", int'(rst_out), 1);
        chk("R9", int'(rst_out), 1);
        vmain_low = 1'b0;
        edges_until(1'b0, n);
        chk("R2", n, HOLD + 3);
        chk("R11", int'(v2_fail), 1);
        v2_low = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", int'(v2_fail), 0);

        // R9 full interval after low-rail release
        cur_req = "R9";
        edges_until(1'b1, n);
        chk("R9", n, W1 - 2);
        edges_until(1'b0, n);
        edges_until(1'b1, n);
        chk("R9", n, W1);
        edges_until(1'b0, n);

        // R7 disabled watchdog
        cur_req = "R7";
        write_sel(2'b11);
        repeat (3 * W2) @(negedge clk);
        chk("R7", int'(rst_out), 0);
        power_cycle();
        edges_until(1'b0, n);
        repeat (3 * W2) @(negedge clk);
        chk("R7", int'(rst_out), 0);
        chk("R8", int'(rst_out), 0);

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual %0d expected below 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule